// File: doc/BRIEF.md
# Synchronous Data In Entry Capture

This block sits in the receive path of a bus initiator. It watches the bus phase. When the phase turns to Data In while a nonzero synchronous offset is programmed, it treats that moment as an entry event. On that event it shuts off the path to the DMA engine and records how many bytes were still waiting in its 16-byte receive FIFO. Those bytes are then discarded and the FIFO is emptied. The block also pulses an interrupt. After the entry cycle it keeps taking incoming Data In bytes into the emptied FIFO. It stops taking them only when the count of bytes received but not yet acknowledged reaches the programmed offset.

Bytes reach the block over a valid/ready stream from the bus receiver. A byte is taken when `rx_valid` and `rx_ready` are both high at a rising edge. The receiver must hold the byte and its parity-error bit steady until that happens. Each byte taken counts as one received request. Each `ack_pulse` from the handshake timing logic lowers the outstanding count by one.

The FIFO drains over a second valid/ready stream to DMA. The output byte stays steady while `dma_valid` is high and `dma_ready` is low. A transfer command from the processor turns the DMA path back on. The same command releases any parity error that was held back during the synchronous burst. Parity errors seen in other input phases, such as Message In and Status, raise the parity flag and the attention line at once.

Top module: `sdi_entry_ctrl`

## Requirements
- R1: After reset, `irq`, `parity_flag`, `atn` and `dma_valid` are low and `lost_count` is 0.
- R2: An entry event happens only in a cycle where `bus_phase` is Data In (3'b001), the phase sampled at the previous edge was not Data In, and `sync_offset` is nonzero. If `sync_offset` is zero there is no interrupt, and neither the FIFO nor `lost_count` changes.
- R3: On an entry event, `lost_count` takes the FIFO occupancy from just before the event. `irq` is high for exactly the one cycle that follows the event.
- R4: `dma_valid` is low in the entry cycle and stays low after it until `xfer_cmd` is sampled high outside an entry cycle. From the next cycle on, `dma_valid` is high whenever the FIFO holds data.
- R5: `rx_ready` is low in the entry cycle. Bytes taken after the entry cycle come out on `dma_data` in the order they arrived.
- R6: During synchronous Data In, `rx_ready` is low while the outstanding count is at or above `sync_offset`. The outstanding count is bytes taken minus `ack_pulse` cycles, it never goes below 0, and it is cleared on entry. `rx_ready` is also low whenever the FIFO holds 16 bytes.
- R7: A byte taken with `rx_par_err` high outside synchronous Data In (for example in Message In 3'b111 or Status 3'b011) sets `parity_flag` and `atn` on the next cycle.
- R8: A byte taken with `rx_par_err` high during synchronous Data In sets a held error. It changes neither `parity_flag` nor `atn` until the next accepted `xfer_cmd`, including a command in the same cycle as the error. That command sets both outputs and clears the held error, so a later command with no new error sets nothing.
- R9: `atn` falls one cycle after `bus_phase` is Message Out (3'b110). `parity_flag` falls one cycle after `flag_clr`. In both cases a new error in that cycle takes priority.
- R10: While `dma_valid` is high and `dma_ready` is low, `dma_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_phase | input | 3 | Current bus phase code |
| sync_offset | input | 5 | Programmed synchronous offset; zero means asynchronous |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can take the incoming byte |
| rx_data | input | 8 | Incoming byte |
| rx_par_err | input | 1 | Parity error on the incoming byte |
| ack_pulse | input | 1 | One acknowledge sent on the bus this cycle |
| dma_valid | output | 1 | FIFO byte offered to DMA |
| dma_ready | input | 1 | DMA takes the offered byte |
| dma_data | output | 8 | Byte at the FIFO head |
| xfer_cmd | input | 1 | Transfer command pulse from the processor |
| flag_clr | input | 1 | Clears the parity flag |
| irq | output | 1 | One-cycle entry interrupt |
| lost_count | output | 5 | FIFO occupancy captured at the last entry |
| parity_flag | output | 1 | Parity error status flag |
| atn | output | 1 | Attention request to the target |

## Verification
There are two kinds of results, with different timing. `rx_ready` and `dma_valid` are combinational: they reflect the current phase, FIFO and counters in the same cycle, so the entry gating shows with no delay. `irq`, `lost_count`, `parity_flag`, `atn`, the DMA enable and the FIFO contents change one edge after the inputs that cause them. The bench drives its inputs just after the falling edge and compares every output shortly afterwards. Its behavioural model moves to the next state only at the rising edge, so every registered result is checked in the first cycle it is due, and every combinational result is checked in the cycle where it applies.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef logic [2:0] bus_phase_t;

  // Phase codes decoded by this block.
  localparam bus_phase_t PH_DATA_OUT = 3'b000;
  localparam bus_phase_t PH_DATA_IN  = 3'b001;
  localparam bus_phase_t PH_MSG_OUT  = 3'b110;
endpackage

// File: rtl/sdi_phase_track.sv
module sdi_phase_track
  import sdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_phase_t bus_phase,
  input  logic       sync_mode,
  output logic       entry,
  output logic       sync_active
);
  bus_phase_t prev_q;
  logic       in_din;

  assign in_din = (bus_phase == PH_DATA_IN);
  // Edge into Data In while the offset marks the link synchronous.
  assign entry  = in_din && (prev_q != PH_DATA_IN) && sync_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= PH_DATA_OUT;
      sync_active <= 1'b0;
    end else begin
      prev_q <= bus_phase;
      if (entry)        sync_active <= 1'b1;
      else if (!in_din) sync_active <= 1'b0;
    end
  end
endmodule

// File: rtl/sdi_byte_fifo.sv
module sdi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] count_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/sdi_offset_window.sv
module sdi_offset_window #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             req_seen,
  input  logic             ack_seen,
  input  logic [OFS_W-1:0] limit,
  output logic             stall,
  output logic [OFS_W-1:0] outstanding
);
  logic dec;

  assign dec = ack_seen && (outstanding != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      outstanding <= '0;
    end else if (active) begin
      case ({req_seen, dec})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  assign stall = active && (outstanding >= limit);
endmodule

// File: rtl/sdi_parity_defer.sv
module sdi_parity_defer (
  input  logic clk,
  input  logic rst_n,
  input  logic err_now,
  input  logic err_later,
  input  logic report,
  input  logic atn_drop,
  input  logic flag_drop,
  output logic parity_flag,
  output logic atn
);
  logic pending_q;
  logic fire;
  logic raise;

  assign fire  = report && (pending_q || err_later);
  assign raise = err_now || fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      parity_flag <= 1'b0;
      atn         <= 1'b0;
    end else begin
      if (report)         pending_q <= 1'b0;
      else if (err_later) pending_q <= 1'b1;

      if (raise)          parity_flag <= 1'b1;
      else if (flag_drop) parity_flag <= 1'b0;

      if (raise)          atn <= 1'b1;
      else if (atn_drop)  atn <= 1'b0;
    end
  end
endmodule

// File: rtl/sdi_entry_ctrl.sv
module sdi_entry_ctrl
  import sdi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2:0]                        bus_phase,
  input  logic [OFS_W-1:0]                  sync_offset,
  input  logic                              rx_valid,
  output logic                              rx_ready,
  input  logic [DATA_W-1:0]                 rx_data,
  input  logic                              rx_par_err,
  input  logic                              ack_pulse,
  output logic                              dma_valid,
  input  logic                              dma_ready,
  output logic [DATA_W-1:0]                 dma_data,
  input  logic                              xfer_cmd,
  input  logic                              flag_clr,
  output logic                              irq,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   lost_count,
  output logic                              parity_flag,
  output logic                              atn
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              entry;
  logic              sync_active;
  logic              push, pop;
  logic              fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_count;
  logic [DATA_W-1:0] fifo_dout;
  logic              ofs_stall;
  logic [OFS_W-1:0]  outstanding;
  logic              dma_en_q;
  logic              cmd_ok;
  logic              err_now, err_later;

  sdi_phase_track u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_phase  (bus_phase),
    .sync_mode  (|sync_offset),
    .entry      (entry),
    .sync_active(sync_active)
  );

  // Stream edges: entry blocks both sides in the cycle it happens.
  assign rx_ready  = !entry && !fifo_full && !ofs_stall;
  assign push      = rx_valid && rx_ready;
  assign dma_valid = dma_en_q && !entry && !fifo_empty;
  assign pop       = dma_valid && dma_ready;
  assign dma_data  = fifo_dout;

  sdi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(entry),
    .push (push),
    .din  (rx_data),
    .pop  (pop),
    .dout (fifo_dout),
    .count(fifo_count),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  sdi_offset_window #(.OFS_W(OFS_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (entry),
    .active     (sync_active),
    .req_seen   (push),
    .ack_seen   (ack_pulse),
    .limit      (sync_offset),
    .stall      (ofs_stall),
    .outstanding(outstanding)
  );

  assign cmd_ok    = xfer_cmd && !entry;
  assign err_now   = push && rx_par_err && !sync_active;
  assign err_later = push && rx_par_err && sync_active;

  sdi_parity_defer u_parity (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_now    (err_now),
    .err_later  (err_later),
    .report     (cmd_ok),
    .atn_drop   (bus_phase == PH_MSG_OUT),
    .flag_drop  (flag_clr),
    .parity_flag(parity_flag),
    .atn        (atn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en_q   <= 1'b0;
      irq        <= 1'b0;
      lost_count <= '0;
    end else begin
      irq <= entry;
      if (entry) begin
        dma_en_q   <= 1'b0;
        lost_count <= fifo_count;
      end else if (cmd_ok) begin
        dma_en_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdi_entry_chk.sv
module sdi_entry_chk
  import sdi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 5
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [2:0]                       bus_phase,
  input logic [OFS_W-1:0]                 sync_offset,
  input logic                             rx_valid,
  input logic                             rx_ready,
  input logic                             rx_par_err,
  input logic                             dma_valid,
  input logic                             dma_ready,
  input logic [DATA_W-1:0]                dma_data,
  input logic                             xfer_cmd,
  input logic                             irq,
  input logic                             parity_flag,
  input logic                             atn,
  input logic                             entry,
  input logic                             sync_active,
  input logic [OFS_W-1:0]                 outstanding,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  fifo_count
);
  logic taken_err;
  assign taken_err = rx_valid && rx_ready && rx_par_err;

  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_dma_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !dma_valid);

  p_entry_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry |-> !rx_ready);

  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_active && (outstanding >= sync_offset)) |-> !rx_ready);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)) |-> !rx_ready);

  p_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_err && !sync_active) |=> (parity_flag && atn));

  p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_err && sync_active && !xfer_cmd && !parity_flag) |=> !parity_flag);

  p_atn_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_phase == PH_MSG_OUT) && !taken_err && !xfer_cmd) |=> !atn);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> (!dma_valid || $stable(dma_data)));
endmodule

bind sdi_entry_ctrl sdi_entry_chk #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .DATA_W    (DATA_W),
  .OFS_W     (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_phase  (bus_phase),
  .sync_offset(sync_offset),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_par_err (rx_par_err),
  .dma_valid  (dma_valid),
  .dma_ready  (dma_ready),
  .dma_data   (dma_data),
  .xfer_cmd   (xfer_cmd),
  .irq        (irq),
  .parity_flag(parity_flag),
  .atn        (atn),
  .entry      (entry),
  .sync_active(sync_active),
  .outstanding(outstanding),
  .fifo_count (fifo_count)
);

// File: tb/test_sdi_entry_ctrl.sv
module test_sdi_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_phase;
  logic [4:0] sync_offset;
  logic       rx_valid, rx_ready, rx_par_err, ack_pulse;
  logic [7:0] rx_data;
  logic       dma_valid, dma_ready;
  logic [7:0] dma_data;
  logic       xfer_cmd, flag_clr, irq, parity_flag, atn;
  logic [4:0] lost_count;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdi_entry_ctrl i_sdi_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .sync_offset(sync_offset),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .ack_pulse(ack_pulse), .dma_valid(dma_valid),
    .dma_ready(dma_ready), .dma_data(dma_data), .xfer_cmd(xfer_cmd),
    .flag_clr(flag_clr), .irq(irq), .lost_count(lost_count),
    .parity_flag(parity_flag), .atn(atn)
  );

  // Behavioural reference state.
  logic [7:0] q[$];
  int         m_outs, m_lost;
  bit         m_den, m_irq, m_sact, m_pend, m_flag, m_atn;
  logic [2:0] m_prev;
  bit         acc;
  int         n_chk, n_fail;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic model_reset();
    q.delete();
    m_outs = 0; m_lost = 0; m_den = 0; m_irq = 0; m_sact = 0;
    m_pend = 0; m_flag = 0; m_atn = 0; m_prev = 3'b000;
  endtask

  task automatic quiet();
    rx_valid = 0; rx_par_err = 0; ack_pulse = 0; xfer_cmd = 0;
    flag_clr = 0; dma_ready = 0;
  endtask

  // One clock: compare, advance model at the rising edge, return at the falling edge.
  task automatic step();
    bit ent, e_rdy, e_val, push, pop, cmd_ok, now_err, late_err, fire;
    #1;
    ent   = (bus_phase == 3'b001) && (m_prev != 3'b001) && (sync_offset != 0);
    e_rdy = !ent && (q.size() < DEPTH) && !(m_sact && m_outs >= int'(sync_offset));
    e_val = m_den && !ent && (q.size() > 0);
    chk("R6", rx_ready, e_rdy, "rx_ready");
    chk("R4", dma_valid, e_val, "dma_valid");
    if (e_val) chk("R5", dma_data, q[0], "dma_data");
    chk("R3", irq, m_irq, "irq");
    chk("R3", lost_count, m_lost, "lost_count");
    chk("R8", parity_flag, m_flag, "parity_flag");
    chk("R7", atn, m_atn, "atn");
    push = rx_valid && e_rdy;
    pop  = e_val && dma_ready;
    acc  = push;
    @(posedge clk);
    cmd_ok   = xfer_cmd && !ent;
    now_err  = push && rx_par_err && !m_sact;
    late_err = push && rx_par_err && m_sact;
    fire     = cmd_ok && (m_pend || late_err);
    if (cmd_ok) m_pend = 0; else if (late_err) m_pend = 1;
    if (now_err || fire) begin m_flag = 1; m_atn = 1; end
    else begin
      if (flag_clr) m_flag = 0;
      if (bus_phase == 3'b110) m_atn = 0;
    end
    if (ent) m_outs = 0;
    else if (m_sact) begin
      if (push && !(ack_pulse && m_outs > 0)) m_outs++;
      else if (!push && ack_pulse && m_outs > 0) m_outs--;
    end
    if (ent) begin m_lost = q.size(); q.delete(); end
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(rx_data);
    end
    m_irq = ent;
    if (ent) m_den = 0; else if (cmd_ok) m_den = 1;
    if (ent) m_sact = 1; else if (bus_phase != 3'b001) m_sact = 0;
    m_prev = bus_phase;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic [2:0] phases [5] = '{3'b000, 3'b001, 3'b011, 3'b110, 3'b111};
    n_chk = 0; n_fail = 0;
    quiet();
    rst_n = 0; bus_phase = 3'b111; sync_offset = 0; rx_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", irq, 0, "irq"); chk("R1", parity_flag, 0, "parity_flag");
    chk("R1", atn, 0, "atn"); chk("R1", lost_count, 0, "lost_count");
    chk("R1", dma_valid, 0, "dma_valid");
    @(negedge clk);

    // R7: parity error in Message In raises flag and ATN at once.
    for (int i = 0; i < 3; i++) begin
      rx_valid = 1; rx_data = 8'h10 + 8'(i); rx_par_err = (i == 1); step();
    end
    quiet(); step();
    chk("R7", parity_flag, 1, "flag after msg-in error");
    chk("R7", atn, 1, "atn after msg-in error");

    // R9: Message Out drops ATN, clear drops the flag.
    bus_phase = 3'b110; step();
    chk("R9", atn, 0, "atn in message out");
    flag_clr = 1; step(); flag_clr = 0;
    chk("R9", parity_flag, 0, "flag after clear");

    // Enable DMA and drain the message bytes.
    xfer_cmd = 1; step(); xfer_cmd = 0;
    dma_ready = 1; repeat (4) step(); dma_ready = 0;

    // Status bytes held by a stalled DMA.
    bus_phase = 3'b011;
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1; rx_data = 8'h20 + 8'(i); step();
    end
    rx_valid = 0; step();
    held = dma_data;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10", dma_data, held, "dma_data under stall");
      chk("R10", dma_valid, 1, "dma_valid under stall");
    end

    // Entry into synchronous Data In with offset 4.
    sync_offset = 5'd4; bus_phase = 3'b001;
    #1 chk("R5", rx_ready, 0, "rx_ready in entry cycle");
    step();
    chk("R3", irq, 1, "irq after entry");
    chk("R3", lost_count, 5, "lost_count after entry");
    chk("R4", dma_valid, 0, "dma after entry");
    step();
    chk("R3", irq, 0, "irq second cycle");

    // Burst limited by the offset; one parity error held back.
    rx_data = 8'h40;
    for (int i = 0; i < 10; i++) begin
      rx_valid = 1; rx_par_err = (rx_data == 8'h41);
      ack_pulse = (i == 6 || i == 7);
      step();
      if (acc) rx_data = rx_data + 1;
    end
    quiet();
    chk("R6", rx_ready, 0, "rx_ready at offset limit");
    chk("R8", parity_flag, 0, "flag held during burst");
    chk("R8", atn, 0, "atn held during burst");

    // R8: transfer command releases the held error and re-enables DMA.
    xfer_cmd = 1; step(); xfer_cmd = 0;
    chk("R8", parity_flag, 1, "flag after command");
    chk("R8", atn, 1, "atn after command");
    for (int i = 0; i < 20; i++) begin dma_ready = 1'($urandom_range(0, 1)); step(); end
    quiet();

    // Held error is consumed: a second command raises nothing.
    flag_clr = 1; bus_phase = 3'b110; step(); flag_clr = 0;
    xfer_cmd = 1; step(); xfer_cmd = 0; step();
    chk("R8", parity_flag, 0, "flag after second command");
    chk("R9", atn, 0, "atn after message out");

    // R2: offset zero does not count as entry.
    sync_offset = 0; bus_phase = 3'b000; step();
    bus_phase = 3'b001; step();
    chk("R2", irq, 0, "irq with zero offset");
    step();
    chk("R2", lost_count, 5, "lost_count with zero offset");

    // R6: FIFO full stops intake even with a wide window.
    sync_offset = 5'd31; bus_phase = 3'b000; step();
    bus_phase = 3'b001;
    rx_data = 8'h60;
    for (int i = 0; i < 22; i++) begin
      rx_valid = 1; ack_pulse = 1; step();
      if (acc) rx_data = rx_data + 1;
    end
    chk("R6", rx_ready, 0, "rx_ready with full FIFO");
    quiet();

    // Mixed traffic compared cycle by cycle.
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(0, 9) == 0) bus_phase = phases[$urandom_range(0, 4)];
      if ($urandom_range(0, 19) == 0) sync_offset = 5'($urandom_range(0, 7));
      rx_valid   = 1'($urandom_range(0, 1));
      rx_data    = 8'($urandom);
      rx_par_err = ($urandom_range(0, 7) == 0);
      ack_pulse  = 1'($urandom_range(0, 1));
      xfer_cmd   = ($urandom_range(0, 15) == 0);
      flag_clr   = ($urandom_range(0, 31) == 0);
      dma_ready  = 1'($urandom_range(0, 1));
      step();
    end
    quiet(); step();

    report();
    $finish;
  end
endmodule